// File: doc/BRIEF.md
# Multi-Position 20-Bit Shift Unit

This unit shifts a 20-bit operand by one to four bit positions, moving one position per clock. Four kinds of shift are supported: right through the carry, unsigned right, arithmetic right, and arithmetic left. Each operation runs on either the low 16 bits (word mode) or the full 20 bits (address mode). The incoming carry takes part in the shift.

A single-cycle start pulse loads the operand, the count, the kind, the mode and the carry-in. The unit stays busy for one cycle per position. It then raises done for one cycle. At that point it presents the result together with carry, zero, negative and overflow flags. These hold until the next operation is accepted. A datapath sequencer issues the operation and collects the result on done.

Top module: `shift20_unit`

## Requirements
- R1: `cnt_i` holds the count minus one, so 0..3 selects 1..4 positions. If start is taken at clock edge k, busy_o is high after edges k..k+n-1 and done_o is high only after edge k+n, where n is the count.
- R2: In word mode (`addr_mode_i`=0), operand bits 19:16 are ignored and result bits 19:16 are zero. The most significant bit is bit 15.
- R3: In address mode (`addr_mode_i`=1), all 20 bits take part and the most significant bit is bit 19.
- R4: Kind 0 (rotate right through carry): on each step the carry moves into the MSB and the LSB moves into the carry.
- R5: Kind 1 (unsigned right): on each step a zero moves into the MSB and the LSB moves into the carry.
- R6: Kind 2 (arithmetic right): on each step the MSB keeps its value and the LSB moves into the carry, which divides a signed value by 2, 4, 8 or 16.
- R7: Kind 3 (arithmetic left): on each step the MSB moves into the carry and a zero enters the LSB, which multiplies by 2, 4, 8 or 16.
- R8: At done, `c_o` is the last bit shifted out, `n_o` is the result MSB for the mode in use, `z_o` is set exactly when the result is zero, and `v_o` is zero.
- R9: done_o lasts one cycle. result_o and the flags stay unchanged after done until another start is accepted.
- R10: A start pulse that arrives while busy_o is high is ignored. The operation in progress completes with its own operands and timing.
- R11: After reset, busy_o, done_o, result_o and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; taken only when idle |
| operand_i | input | 20 | Value to shift |
| cnt_i | input | 2 | Positions minus one |
| kind_i | input | 2 | 0 rotate-right-carry, 1 unsigned right, 2 arithmetic right, 3 arithmetic left |
| addr_mode_i | input | 1 | 1 = 20-bit, 0 = 16-bit |
| carry_i | input | 1 | Carry-in |
| busy_o | output | 1 | Shift in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 20 | Shifted value |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag, always cleared |

## Verification
The bench targets word-mode operands with bits 19:16 set. A unit that fails to mask them returns a nonzero upper nibble or takes the sign from bit 19. It runs four-position shifts on operands of all ones and of a lone MSB. There, an off-by-one counter gives a result that is off by a factor of two, and a sign bit that is not kept fills the top with zeros. Carry-in is exercised for the rotate kind, where losing it clears the new MSB. A start sent in mid-operation must leave both the result and the done timing unchanged; a unit that restarts shows a late done or the second operand.

// File: rtl/shift20_pkg.sv
package shift20_pkg;
  localparam int unsigned DATA_W = 20;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CNT_W  = 2;

  typedef enum logic [1:0] {
    SK_RRC = 2'd0,
    SK_RRU = 2'd1,
    SK_RRA = 2'd2,
    SK_RLA = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shift20_step.sv
module shift20_step
  import shift20_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned WW = WORD_W
) (
  input  logic [DW-1:0] data_i,
  input  logic          carry_i,
  input  shift_kind_e   kind_i,
  input  logic          wide_i,
  output logic [DW-1:0] data_o,
  output logic          carry_o
);
  localparam int unsigned IW = $clog2(DW);
  localparam logic [DW-1:0] WIDE_MASK = {DW{1'b1}};
  localparam logic [DW-1:0] WORD_MASK = {{(DW-WW){1'b0}}, {WW{1'b1}}};

  logic [DW-1:0] mask, d, r;
  logic [IW-1:0] msb;

  always_comb begin
    mask = wide_i ? WIDE_MASK : WORD_MASK;
    msb  = wide_i ? IW'(DW-1) : IW'(WW-1);
    d    = data_i & mask;
    r    = d >> 1;
    carry_o = d[0];
    unique case (kind_i)
      SK_RRC: r[msb] = carry_i;
      SK_RRU: r[msb] = 1'b0;
      SK_RRA: r[msb] = d[msb];
      SK_RLA: begin
        r       = d << 1;
        carry_o = d[msb];
      end
      default: r = d;
    endcase
    data_o = r & mask;
  end
endmodule

// File: rtl/shift20_flags.sv
module shift20_flags
  import shift20_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned WW = WORD_W
) (
  input  logic [DW-1:0] value_i,
  input  logic          wide_i,
  output logic          zero_o,
  output logic          neg_o
);
  always_comb begin
    zero_o = (value_i == '0);
    neg_o  = wide_i ? value_i[DW-1] : value_i[WW-1];
  end
endmodule

// File: rtl/shift20_ctrl.sv
module shift20_ctrl
  import shift20_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          step_o,
  output logic          last_o
);
  localparam int unsigned RW = CW + 1;

  logic [RW-1:0] rem_q;
  logic          busy_q, done_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q & (rem_q == RW'(1));
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        rem_q  <= RW'(cnt_i) + RW'(1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_q - RW'(1);
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/shift20_unit.sv
module shift20_unit
  import shift20_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        kind_i,
  input  logic              addr_mode_i,
  input  logic              carry_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              c_o,
  output logic              z_o,
  output logic              n_o,
  output logic              v_o
);
  localparam logic [DATA_W-1:0] WORD_MASK = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

  logic              load, step, last;
  logic [DATA_W-1:0] data_q, step_data;
  logic              carry_q, step_carry;
  shift_kind_e       kind_q;
  logic              wide_q;
  logic              c_q, z_q, n_q, nz, nn;

  shift20_ctrl #(.CW(CNT_W)) ctrl_i (
    .clk_i, .rst_ni, .start_i, .cnt_i,
    .busy_o, .done_o,
    .load_o(load), .step_o(step), .last_o(last)
  );

  shift20_step #(.DW(DATA_W), .WW(WORD_W)) step_i (
    .data_i(data_q), .carry_i(carry_q), .kind_i(kind_q), .wide_i(wide_q),
    .data_o(step_data), .carry_o(step_carry)
  );

  shift20_flags #(.DW(DATA_W), .WW(WORD_W)) flags_i (
    .value_i(step_data), .wide_i(wide_q), .zero_o(nz), .neg_o(nn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      carry_q <= 1'b0;
      kind_q  <= SK_RRC;
      wide_q  <= 1'b0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
      n_q     <= 1'b0;
    end else if (load) begin
      data_q  <= addr_mode_i ? operand_i : (operand_i & WORD_MASK);
      carry_q <= carry_i;
      kind_q  <= shift_kind_e'(kind_i);
      wide_q  <= addr_mode_i;
    end else if (step) begin
      data_q  <= step_data;
      carry_q <= step_carry;
      if (last) begin
        c_q <= step_carry;
        z_q <= nz;
        n_q <= nn;
      end
    end
  end

  assign result_o = data_q;
  assign c_o      = c_q;
  assign z_o      = z_q;
  assign n_o      = n_q;
  assign v_o      = 1'b0;
endmodule

// File: rtl/shift20_unit_chk.sv
module shift20_unit_chk
  import shift20_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              addr_mode_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o,
  input logic              z_o
);
  logic wide_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wide_cap <= 1'b0;
    else if (start_i && !busy_o) wide_cap <= addr_mode_i;
  end

  p_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  p_busy_done_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_word_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !wide_cap |-> result_o[DATA_W-1:WORD_W] == '0);
  p_zero_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> z_o == (result_o == '0));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(result_o) && $stable(z_o));
  p_ignore_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o);
endmodule

bind shift20_unit shift20_unit_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_mode_i(addr_mode_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .z_o(z_o)
);

// File: tb/shift20_unit_tb_top.sv
`timescale 1ns/1ps
module shift20_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [19:0] operand_i = '0;
  logic [1:0]  cnt_i = '0;
  logic [1:0]  kind_i = '0;
  logic        addr_mode_i = 1'b0;
  logic        carry_i = 1'b0;
  logic        busy_o, done_o, c_o, z_o, n_o, v_o;
  logic [19:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  shift20_unit dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns {c, z, n, result}
  function automatic logic [22:0] model(input logic [19:0] op, input logic [1:0] cnt,
                                        input logic [1:0] kind, input logic wide, input logic cin);
    logic [19:0] m, d;
    logic c;
    int top;
    m   = wide ? 20'hFFFFF : 20'h0FFFF;
    top = wide ? 19 : 15;
    d   = op & m;
    c   = cin;
    for (int i = 0; i <= int'(cnt); i++) begin
      logic lsb, hi;
      lsb = d[0];
      hi  = d[top];
      if (kind == 2'd3) begin
        c = hi;
        d = (d << 1) & m;
      end else begin
        d = d >> 1;
        if (kind == 2'd0) d[top] = c;
        else if (kind == 2'd2) d[top] = hi;
        c = lsb;
      end
    end
    return {c, (d == 20'h0), d[top], d};
  endfunction

  task automatic run_op(input logic [19:0] op, input logic [1:0] cnt, input logic [1:0] kind,
                        input logic wide, input logic cin, input string req,
                        input bit poke = 0);
    logic [22:0] e;
    int cyc;
    e = model(op, cnt, kind, wide, cin);
    operand_i = op; cnt_i = cnt; kind_i = kind; addr_mode_i = wide; carry_i = cin;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 1;
    if (poke) begin
      operand_i = ~op; cnt_i = 2'd3; kind_i = ~kind; addr_mode_i = ~wide; carry_i = ~cin;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      cyc++;
    end
    while (!done_o && cyc < 20) begin
      @(negedge clk_i);
      cyc++;
    end
    chk(cyc == int'(cnt) + 2, {req, " R1 latency"}, cyc, int'(cnt) + 2);
    chk(result_o == e[19:0], {req, " result"}, result_o, e[19:0]);
    chk({c_o, z_o, n_o, v_o} == {e[22:20], 1'b0}, {req, " R8 flags"},
        {c_o, z_o, n_o, v_o}, {e[22:20], 1'b0});
    @(negedge clk_i);
    chk(!done_o && result_o == e[19:0] && {c_o, z_o, n_o} == e[22:20], {req, " R9 hold"},
        {done_o, result_o}, {1'b0, e[19:0]});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, result_o, c_o, z_o, n_o, v_o} == '0, "R11 reset",
        {busy_o, done_o, result_o, c_o, z_o, n_o, v_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_op(20'h00001, 2'd0, 2'd0, 1'b0, 1'b1, "R4 rrc carry-in to bit15");
    run_op(20'h00003, 2'd3, 2'd0, 1'b1, 1'b0, "R4 rrc wide");
    run_op(20'hFFFFF, 2'd3, 2'd1, 1'b1, 1'b1, "R5 rru wide");
    run_op(20'hF8001, 2'd2, 2'd1, 1'b0, 1'b1, "R5 rru word");
    run_op(20'h80000, 2'd3, 2'd2, 1'b1, 1'b0, "R6 rra wide sign");
    run_op(20'h08000, 2'd3, 2'd2, 1'b0, 1'b0, "R6 rra word sign");
    run_op(20'hA1234, 2'd1, 2'd3, 1'b0, 1'b0, "R7 rla word");
    run_op(20'h48000, 2'd3, 2'd3, 1'b1, 1'b0, "R7 rla wide");
    run_op(20'hF0000, 2'd0, 2'd2, 1'b0, 1'b1, "R2 upper ignored zero");
    run_op(20'hF7FFF, 2'd0, 2'd3, 1'b0, 1'b0, "R2 word msb15");
    run_op(20'h40000, 2'd0, 2'd3, 1'b1, 1'b0, "R3 wide msb19");
    run_op(20'h12345, 2'd2, 2'd2, 1'b1, 1'b1, "R10 start while busy", 1);
    run_op(20'h0FFFF, 2'd0, 2'd1, 1'b0, 1'b0, "R10 early poke", 1);

    for (int i = 0; i < 300; i++) begin
      run_op(20'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
             "R4-7 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule